// File: doc/BRIEF.md
# Cascadable Channel Readout Sequencer

This block steps through the channel addresses of an analog readout multiplexer, one channel at a time. It runs on the system clock. A single-cycle pixel-advance strobe stands for each pixel clock, and a frame-go input starts a scan. Frame-go is only acted on in a cycle where the pixel-advance strobe is also high. Once a scan has started, each pixel advance moves the enabled channel forward by one. After the last channel the sequencer goes idle, and no channel stays enabled.

The block gives the channel index in binary and as a one-hot enable vector. A valid flag marks both as meaningful. A first-channel marker shows the time slot of channel 1, so external logic can synchronise to it. A last-channel marker is high during the final slot. Wired to the frame-go input of the next device, it starts that device on the very pixel advance that ends this scan, so several devices can be chained with no gap between them. All outputs are plain registered levels and there is no handshake. The pixel-advance strobe must stay within the readout rate that the analog side can follow.

Top module: `readout_seq`

## Requirements
- R1: In reset and right after it, `ch_valid`, `ch_onehot`, `first_mark` and `last_mark` are 0 and `ch_addr` is 0.
- R2: A cycle with `pix_adv`=1 and `frame_go`=1 puts the sequencer in channel index 0 (channel 1), with `ch_valid`=1 from the next cycle on.
- R3: While scanning, each cycle with `pix_adv`=1 and `frame_go`=0 raises `ch_addr` by one. If index NCH-1 (default 31) has not yet been reached, `ch_valid` stays 1.
- R4: `ch_onehot` has exactly bit `ch_addr` set while `ch_valid`=1, and it is all zero while `ch_valid`=0.
- R5: `first_mark` is 1 exactly when `ch_valid`=1 and `ch_addr`=0.
- R6: `last_mark` is 1 exactly when `ch_valid`=1 and `ch_addr`=NCH-1.
- R7: A cycle with `pix_adv`=1 and `frame_go`=0 while at index NCH-1 ends the scan: `ch_valid` goes to 0 and stays 0 until the next accepted frame-go. Every channel is enabled exactly once per scan.
- R8: An accepted frame-go in the middle of a scan restarts it at index 0.
- R9: In cycles with `pix_adv`=0 the outputs hold their values, and `frame_go` has no effect.
- R10: An accepted frame-go arriving in the last-channel slot starts a new scan at index 0 with no idle slot in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_adv | input | 1 | One-cycle strobe per pixel clock |
| frame_go | input | 1 | Scan start, sampled only with pix_adv |
| ch_addr | output | AW (5) | Enabled channel index, 0 = channel 1 |
| ch_onehot | output | NCH (32) | One-hot channel enable |
| ch_valid | output | 1 | A channel is enabled |
| first_mark | output | 1 | Channel-1 slot marker |
| last_mark | output | 1 | Last-channel slot marker, cascade output |

## Verification
The bench targets the scan boundaries, and each boundary catches a different error. An off-by-one end test would enable a 33rd channel or drop the 32nd. A missing idle return would wrap back to channel 1. A restart that is ignored mid-scan, or that lands in the last slot, would carry on from the old index, or would insert an idle slot that breaks a chain of devices. Frame-go is also pulsed without the pixel strobe: a design that samples it unqualified would start a scan early. The marker and one-hot outputs are compared against a behavioural model on every cycle.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SCAN = 1'b1
  } seq_state_t;
endpackage

// File: rtl/readout_seq_ctr.sv
module readout_seq_ctr
  import readout_seq_pkg::*;
#(
  parameter int NCH = 32,
  localparam int AW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_adv,
  input  logic          frame_go,
  output logic [AW-1:0] addr,
  output logic          valid
);
  localparam logic [AW-1:0] LAST = AW'(NCH - 1);

  seq_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      addr  <= '0;
    end else if (pix_adv) begin
      if (frame_go) begin
        state <= SEQ_SCAN;
        addr  <= '0;
      end else if (state == SEQ_SCAN) begin
        if (addr == LAST) begin
          state <= SEQ_IDLE;
          addr  <= '0;
        end else begin
          addr <= addr + AW'(1);
        end
      end
    end
  end

  assign valid = (state == SEQ_SCAN);

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && pix_adv && !frame_go && addr != LAST) |=> (valid && addr == $past(addr) + AW'(1)));
  // R7
  end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && pix_adv && !frame_go && addr == LAST) |=> !valid);
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_adv && frame_go) |=> (valid && addr == '0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_adv |=> ($stable(addr) && $stable(valid)));
endmodule

// File: rtl/readout_seq_dec.sv
module readout_seq_dec #(
  parameter int NCH = 32,
  localparam int AW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           valid,
  output logic [NCH-1:0] onehot,
  output logic           first,
  output logic           last
);
  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign onehot[i] = valid && (addr == AW'(i));
  end

  assign first = onehot[0];
  assign last  = onehot[NCH-1];

  // R4
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(onehot) == (valid ? 1 : 0));
  // R5
  first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first |-> (valid && addr == '0));
  // R6
  last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> (valid && addr == AW'(NCH - 1)));
endmodule

// File: rtl/readout_seq.sv
module readout_seq #(
  parameter int NCH = 32,
  localparam int AW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_adv,
  input  logic           frame_go,
  output logic [AW-1:0]  ch_addr,
  output logic [NCH-1:0] ch_onehot,
  output logic           ch_valid,
  output logic           first_mark,
  output logic           last_mark
);
  readout_seq_ctr #(.NCH(NCH)) u_ctr (
    .clk(clk), .rst_n(rst_n), .pix_adv(pix_adv), .frame_go(frame_go),
    .addr(ch_addr), .valid(ch_valid)
  );

  readout_seq_dec #(.NCH(NCH)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(ch_addr), .valid(ch_valid),
    .onehot(ch_onehot), .first(first_mark), .last(last_mark)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!ch_valid && ch_onehot == '0 && !last_mark));
endmodule

// File: tb/sim_readout_seq.sv
module sim_readout_seq;
  localparam int NCH = 32;
  localparam int AW  = $clog2(NCH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_adv = 1'b0;
  logic frame_go = 1'b0;
  logic [AW-1:0]  ch_addr;
  logic [NCH-1:0] ch_onehot;
  logic ch_valid, first_mark, last_mark;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int m_act = 0;
  int m_addr = 0;

  always #4 clk = ~clk;

  readout_seq #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_adv(pix_adv), .frame_go(frame_go),
    .ch_addr(ch_addr), .ch_onehot(ch_onehot), .ch_valid(ch_valid),
    .first_mark(first_mark), .last_mark(last_mark)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act  <= 0;
      m_addr <= 0;
    end else if (pix_adv) begin
      if (frame_go) begin
        m_act <= 1; m_addr <= 0;
      end else if (m_act == 1) begin
        if (m_addr == NCH - 1) begin m_act <= 0; m_addr <= 0; end
        else m_addr <= m_addr + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      longint exp_oh;
      exp_oh = (m_act == 1) ? (longint'(1) << m_addr) : 0;
      chk("R3 ch_valid", ch_valid, m_act);
      if (m_act == 1) chk("R3 ch_addr", ch_addr, m_addr);
      chk("R4 ch_onehot", ch_onehot, exp_oh);
      chk("R5 first_mark", first_mark, (m_act == 1 && m_addr == 0));
      chk("R6 last_mark", last_mark, (m_act == 1 && m_addr == NCH - 1));
    end
  end

  task automatic tick(input bit go);
    @(negedge clk);
    pix_adv = 1'b1; frame_go = go;
    @(negedge clk);
    pix_adv = 1'b0; frame_go = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : wd
    while (cyc < 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected<20000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", ch_valid, 0);
    chk("R1 onehot in reset", ch_onehot, 0);
    chk("R1 marks in reset", {first_mark, last_mark}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr after reset", ch_addr, 0);
    chk("R1 valid after reset", ch_valid, 0);

    // R9: frame_go without pix_adv is ignored
    frame_go = 1'b1; gap(3); frame_go = 1'b0;
    chk("R9 go without strobe", ch_valid, 0);

    // R2 start
    tick(1'b1);
    chk("R2 start valid", ch_valid, 1);
    chk("R2 start addr", ch_addr, 0);
    chk("R5 first at start", first_mark, 1);
    gap(2);
    chk("R9 hold between strobes", ch_addr, 0);

    // full scan
    for (int i = 1; i < NCH; i++) begin
      tick(1'b0); gap(1);
      chk("R3 scan step", ch_addr, i);
    end
    chk("R6 last slot", last_mark, 1);
    tick(1'b0);
    chk("R7 idle after last", ch_valid, 0);
    tick(1'b0); tick(1'b0);
    chk("R7 stays idle", ch_valid, 0);

    // R8 mid-scan restart
    tick(1'b1);
    for (int i = 0; i < 10; i++) tick(1'b0);
    chk("R8 mid addr before", ch_addr, 10);
    tick(1'b1);
    chk("R8 restart addr", ch_addr, 0);
    chk("R8 restart valid", ch_valid, 1);

    // R10 back-to-back via last slot
    for (int i = 1; i < NCH; i++) tick(1'b0);
    chk("R10 at last", last_mark, 1);
    tick(1'b1);
    chk("R10 chained valid", ch_valid, 1);
    chk("R10 chained addr", ch_addr, 0);

    // pixel strobe every cycle
    for (int i = 1; i < NCH + 3; i++) begin
      @(negedge clk); pix_adv = 1'b1;
    end
    @(negedge clk); pix_adv = 1'b0;
    chk("R7 idle after fast scan", ch_valid, 0);

    // reset mid-scan
    tick(1'b1); tick(1'b0);
    rst_n = 1'b0; gap(2);
    chk("R1 reset mid-scan", ch_valid, 0);
    rst_n = 1'b1; gap(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule